// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block takes the two open-collector lines of a PS/2 keyboard, which idle high, into a synchronous system clock domain. It receives scan codes from them. Each line passes through a multi-flop synchroniser. The keyboard clock is also debounced, so that only a level held for a programmable number of system cycles counts as a transition. A falling edge of the debounced keyboard clock samples the data line. The keyboard changes data only while its clock is high, so the sampled value is stable.

A frame holds eleven bits. The receiver gathers them, checks that the frame is well formed, and hands the eight-bit code to the consumer. A sticky "code available" flag tells the consumer that a code is waiting, and a one-cycle read pulse acknowledges it. A separate error flag reports a malformed frame, or a code that arrived before the previous one was read. The error flag clears itself as soon as the next frame starts. A partial frame whose clock stops for longer than a timeout is dropped.

Top module: `ps2_frame_rx`

## Requirements
- R1: A frame is received as eleven bits, each sampled on a falling edge of the keyboard clock. The order is: start bit, eight data bits with bit 0 first, parity bit, stop bit. A well-formed frame loads its data byte into `code_o` and sets `avail_o`.
- R2: Parity is odd. The data byte and the parity bit must hold an odd number of ones. On a mismatch `err_o` is set, while `avail_o` and `code_o` keep their values.
- R3: The start bit must be 0 and the stop bit must be 1. If either is wrong, `err_o` is set, while `avail_o` and `code_o` keep their values.
- R4: Once set, `avail_o` stays 1 until `rd_pulse` is sampled high. It is then 0 from the next system clock edge on.
- R5: A well-formed frame that completes while `avail_o` is 1, with no `rd_pulse` in the same cycle, is an overrun. `err_o` is set, `avail_o` stays 1, and `code_o` keeps the earlier code.
- R6: `err_o` returns to 0 once the first falling edge of a new frame has been accepted.
- R7: A keyboard clock low pulse shorter than `FILT_CYCLES` system cycles is ignored and does not shift in a bit.
- R8: If no accepted falling edge arrives for `TIMEOUT_CYCLES` system cycles in the middle of a frame, the partial frame is discarded and the receiver waits for a new start bit.
- R9: `rst_n` is active low and asynchronous. While it is low, `code_o` is 0x00 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kb_clk | input | 1 | Keyboard clock line, idle high |
| kb_dat | input | 1 | Keyboard data line, idle high |
| rd_pulse | input | 1 | One-cycle acknowledge of the held code |
| code_o | output | 8 | Most recently accepted scan code |
| avail_o | output | 1 | Sticky flag: an unread code is held |
| err_o | output | 1 | Framing, parity or overrun error |

## Verification
The bench builds the receiver with `FILT_CYCLES` = 4 and `TIMEOUT_CYCLES` = 400. Each keyboard clock phase lasts 20 system cycles. With these values a two-cycle glitch falls clearly below the filter length, while a genuine bit phase lies well above it. The abandoned-frame case takes only a few hundred idle cycles, instead of the thousands the default timeout would need. This lets the glitch, timeout and overrun corner cases run in the same short run as the table of good and corrupted frames.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

  localparam int CODE_W     = 8;
  localparam int FRAME_BITS = 11;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Shifted in from the top bit, so the first bit received ends at bit 0.
  typedef struct packed {
    logic              stop;
    logic              par;
    logic [CODE_W-1:0] data;
    logic              start;
  } frame_t;

endpackage

// File: rtl/ps2rx_line_cond.sv
module ps2rx_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kb_clk,
  input  logic kb_dat,
  output logic fall_stb,
  output logic bit_val
);

  localparam int CW = $clog2(FILT_CYCLES + 1);

  logic [SYNC_STAGES-1:0] clk_sr;
  logic [SYNC_STAGES-1:0] dat_sr;

  // Synchroniser chains, idle value 1.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sr[0] <= 1'b1;
          dat_sr[0] <= 1'b1;
        end else begin
          clk_sr[0] <= kb_clk;
          dat_sr[0] <= kb_dat;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          clk_sr[s] <= 1'b1;
          dat_sr[s] <= 1'b1;
        end else begin
          clk_sr[s] <= clk_sr[s-1];
          dat_sr[s] <= dat_sr[s-1];
        end
      end
    end
  end

  logic clk_s, dat_s;
  assign clk_s = clk_sr[SYNC_STAGES-1];
  assign dat_s = dat_sr[SYNC_STAGES-1];

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;
  logic          fall_d;
  logic          fall_q, bit_q;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (clk_s != filt_q) begin
      if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        filt_d = clk_s;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    fall_d = filt_q & ~filt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= 1'b1;
      fall_q <= 1'b0;
      bit_q  <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
      fall_q <= fall_d;
      if (fall_d) begin
        bit_q <= dat_s;
      end
    end
  end

  assign fall_stb = fall_q;
  assign bit_val  = bit_q;

endmodule

// File: rtl/ps2rx_framer.sv
module ps2rx_framer
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fall_stb,
  input  logic   bit_val,
  output logic   start_stb,
  output logic   done_stb,
  output frame_t frame
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(FRAME_BITS + 1);

  rx_state_e             st_q, st_d;
  logic [BW-1:0]         cnt_q, cnt_d;
  logic [TW-1:0]         tmo_q, tmo_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  start_d, done_d;
  logic                  start_q, done_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    sh_d    = sh_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        tmo_d = '0;
        if (fall_stb) begin
          sh_d    = {bit_val, sh_q[FRAME_BITS-1:1]};
          cnt_d   = BW'(1);
          st_d    = RX_BUSY;
          start_d = 1'b1;
        end
      end
      RX_BUSY: begin
        if (fall_stb) begin
          sh_d  = {bit_val, sh_q[FRAME_BITS-1:1]};
          tmo_d = '0;
          if (cnt_q == BW'(FRAME_BITS - 1)) begin
            cnt_d  = '0;
            st_d   = RX_IDLE;
            done_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (tmo_q == TW'(TIMEOUT_CYCLES - 1)) begin
          cnt_d = '0;
          tmo_d = '0;
          st_d  = RX_IDLE;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      tmo_q   <= '0;
      sh_q    <= '1;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
      sh_q    <= sh_d;
      start_q <= start_d;
      done_q  <= done_d;
    end
  end

  assign start_stb = start_q;
  assign done_stb  = done_q;
  assign frame     = frame_t'(sh_q);

endmodule

// File: rtl/ps2rx_hold.sv
module ps2rx_hold
  import ps2rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_stb,
  input  logic              done_stb,
  input  frame_t            frame,
  input  logic              rd_pulse,
  output logic [CODE_W-1:0] code,
  output logic              avail,
  output logic              err
);

  logic [CODE_W-1:0] code_q, code_d;
  logic              avail_q, avail_d;
  logic              err_q, err_d;
  logic              well_formed;

  assign well_formed = ~frame.start & frame.stop & (^{frame.par, frame.data});

  always_comb begin
    code_d  = code_q;
    avail_d = avail_q;
    err_d   = err_q;
    if (rd_pulse) begin
      avail_d = 1'b0;
    end
    if (start_stb) begin
      err_d = 1'b0;
    end
    if (done_stb) begin
      if (!well_formed) begin
        err_d = 1'b1;
      end else if (avail_q && !rd_pulse) begin
        err_d = 1'b1;
      end else begin
        code_d  = frame.data;
        avail_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      avail_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      code_q  <= code_d;
      avail_q <= avail_d;
      err_q   <= err_d;
    end
  end

  assign code  = code_q;
  assign avail = avail_q;
  assign err   = err_q;

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2rx_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_CYCLES    = 8,
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_clk,
  input  logic              kb_dat,
  input  logic              rd_pulse,
  output logic [CODE_W-1:0] code_o,
  output logic              avail_o,
  output logic              err_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sr;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sr <= 2'b00;
    end else begin
      rst_sr <= {rst_sr[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sr[1];

  logic   fall_stb, bit_val;
  logic   start_stb, done_stb;
  frame_t frame;

  ps2rx_line_cond #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_CYCLES (FILT_CYCLES)
  ) cond_i (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .kb_clk   (kb_clk),
    .kb_dat   (kb_dat),
    .fall_stb (fall_stb),
    .bit_val  (bit_val)
  );

  ps2rx_framer #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) framer_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fall_stb  (fall_stb),
    .bit_val   (bit_val),
    .start_stb (start_stb),
    .done_stb  (done_stb),
    .frame     (frame)
  );

  ps2rx_hold hold_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_stb (start_stb),
    .done_stb  (done_stb),
    .frame     (frame),
    .rd_pulse  (rd_pulse),
    .code      (code_o),
    .avail     (avail_o),
    .err       (err_o)
  );

endmodule

// File: rtl/ps2rx_checker.sv
module ps2rx_checker
  import ps2rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_pulse,
  input logic              start_stb,
  input logic              done_stb,
  input frame_t            frame,
  input logic [CODE_W-1:0] code_o,
  input logic              avail_o,
  input logic              err_o
);

  logic bad_frame;
  assign bad_frame = frame.start | ~frame.stop | ~(^{frame.par, frame.data});

  AST_AVAIL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail_o) |-> $past(done_stb)); // R1

  AST_BAD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb && bad_frame) |=> (err_o && $stable(code_o) && !$rose(avail_o))); // R2

  AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !done_stb) |=> !avail_o); // R4

  AST_STICKY_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !rd_pulse) |=> (avail_o && $stable(code_o))); // R4

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb && !bad_frame && avail_o && !rd_pulse) |=> (err_o && avail_o)); // R5

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> !err_o); // R6

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, done_stb})); // R1

endmodule

bind ps2_frame_rx ps2rx_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .rd_pulse  (rd_pulse),
  .start_stb (start_stb),
  .done_stb  (done_stb),
  .frame     (frame),
  .code_o    (code_o),
  .avail_o   (avail_o),
  .err_o     (err_o)
);

// File: tb/ps2_frame_rx_tb_top.sv
module ps2_frame_rx_tb_top;

  localparam int FILT = 4;
  localparam int TMO  = 400;
  localparam int HALF = 20;

  logic       clk;
  logic       rst_n;
  logic       kb_clk;
  logic       kb_dat;
  logic       rd_pulse;
  logic [7:0] code_o;
  logic       avail_o;
  logic       err_o;

  int n_chk;
  int n_err;

  ps2_frame_rx #(
    .SYNC_STAGES    (2),
    .FILT_CYCLES    (FILT),
    .TIMEOUT_CYCLES (TMO)
  ) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .kb_clk   (kb_clk),
    .kb_dat   (kb_dat),
    .rd_pulse (rd_pulse),
    .code_o   (code_o),
    .avail_o  (avail_o),
    .err_o    (err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: data, flip parity, start, stop, exp avail, exp err, exp code.
  localparam int NV = 7;
  localparam logic [20:0] VEC [NV] = '{
    {8'h1D, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h1D},
    {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF},
    {8'hA5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'hFF},
    {8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF},
    {8'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF},
    {8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h81}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits bits of a frame; optionally checks err_o after the first fall.
  task automatic send(input logic [7:0] d, input logic flip, input logic st,
                      input logic sp, input int nbits, input logic chk_clear);
    logic [10:0] bits;
    bits = {sp, (~^d) ^ flip, d, st};
    for (int i = 0; i < nbits; i++) begin
      kb_dat = bits[i];
      cycles(HALF);
      kb_clk = 1'b0;
      cycles(HALF);
      if (i == 0 && chk_clear) chk("R6", "err after frame start", err_o, 0);
      kb_clk = 1'b1;
    end
    cycles(HALF);
    kb_dat = 1'b1;
    cycles(HALF);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_pulse = 1'b1;
    @(negedge clk);
    rd_pulse = 1'b0;
  endtask

  initial begin
    n_chk    = 0;
    n_err    = 0;
    rst_n    = 1'b0;
    kb_clk   = 1'b1;
    kb_dat   = 1'b1;
    rd_pulse = 1'b0;
    cycles(3);
    chk("R9", "code in reset", code_o, 8'h00);
    chk("R9", "avail in reset", avail_o, 0);
    chk("R9", "err in reset", err_o, 0);
    rst_n = 1'b1;
    cycles(5);

    // Table walk: R1 good frames, R2 parity, R3 start/stop.
    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      send(e[20:13], e[12], e[11], e[10], 11, 1'b0);
      chk("R1/R2/R3", $sformatf("vec%0d avail", v), avail_o, e[9]);
      chk("R1/R2/R3", $sformatf("vec%0d err", v), err_o, e[8]);
      chk("R1/R2/R3", $sformatf("vec%0d code", v), code_o, e[7:0]);
      if (e[9]) begin
        cycles(50);
        chk("R4", "avail held before read", avail_o, 1);
        do_read();
        chk("R4", "avail after read", avail_o, 0);
      end
    end

    // R5 overrun: second good frame while unread.
    send(8'h42, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R5", "first code", code_o, 8'h42);
    send(8'h17, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R5", "overrun err", err_o, 1);
    chk("R5", "overrun avail", avail_o, 1);
    chk("R5", "overrun code kept", code_o, 8'h42);
    do_read();
    // R6: error cleared by next frame start.
    send(8'h29, 1'b0, 1'b0, 1'b1, 11, 1'b1);
    chk("R6", "err after good frame", err_o, 0);
    chk("R1", "code after overrun", code_o, 8'h29);
    do_read();

    // R7: short glitch on keyboard clock must not shift a bit.
    @(negedge clk);
    kb_clk = 1'b0;
    cycles(2);
    kb_clk = 1'b1;
    cycles(HALF);
    send(8'h6B, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R7", "code after glitch", code_o, 8'h6B);
    chk("R7", "err after glitch", err_o, 0);
    do_read();

    // R8: partial frame abandoned after timeout.
    send(8'hFF, 1'b0, 1'b0, 1'b1, 5, 1'b0);
    cycles(TMO + 200);
    chk("R8", "no avail from partial", avail_o, 0);
    send(8'h33, 1'b0, 1'b0, 1'b1, 11, 1'b0);
    chk("R8", "code after timeout", code_o, 8'h33);
    chk("R8", "err after timeout", err_o, 0);

    // R9: asynchronous reset while a code is held.
    chk("R9", "avail before reset", avail_o, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "avail async reset", avail_o, 0);
    chk("R9", "code async reset", code_o, 8'h00);
    cycles(2);
    rst_n = 1'b1;
    cycles(5);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule